// File: doc/BRIEF.md
# Dual-Lane Saturating Bias Adder

This block sits after a matrix-multiply array and adds a per-column bias scalar to each array output, producing the pre-activation value Z = X·W + b for two feature columns at once. Every word is signed 16-bit fixed point with 8 integer bits and 8 fractional bits. Each lane adds its bias word to its data word, clamps the sum to the representable range instead of letting it wrap, and registers the result together with a valid strobe one clock later.

A routing-enable input, taken from the most significant bit of a 4-bit pathway control word, decides what the stage does. When the enable is set, the bias is added. When it is clear, data passes through unchanged with the same latency and the same valid behaviour. The bias words are expected to stay fixed for a whole layer, so they are sampled on the same cycle as the data and are not stored inside the block.

Top module: `biasPairTop`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, both output valids are 0 and both output data words are 0x0000.
- R2: When a lane's input valid is high at a rising edge and the route enable is 1, that lane's output data after the edge equals dataIn + biasIn as a signed 16-bit sum, and its output valid is 1.
- R3: When the exact sum is greater than 32767 (0x7FFF), the output is 0x7FFF.
- R4: When the exact sum is less than -32768, the output is 0x8000.
- R5: When a lane's input valid is low at a rising edge, that lane's output valid is 0 after the edge and its output data keeps its previous value.
- R6: When the route enable is 0 and the input valid is high, the output data after the edge equals dataIn unchanged, whatever biasIn is, and the output valid is 1.
- R7: The two lanes are independent. Each lane's outputs depend only on its own data, bias and valid inputs and on the shared route enable.
- R8: Latency is exactly one clock cycle, and each lane can accept a new sample on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| routeEn | input | 1 | 1 adds the bias, 0 passes data through (bit 3 of the pathway word) |
| biasA | input | 16 | Bias word for lane A, Q8.8 signed |
| biasB | input | 16 | Bias word for lane B, Q8.8 signed |
| dataA | input | 16 | Array output for lane A, Q8.8 signed |
| dataB | input | 16 | Array output for lane B, Q8.8 signed |
| validA | input | 1 | Lane A input valid |
| validB | input | 1 | Lane B input valid |
| zA | output | 16 | Lane A result |
| zB | output | 16 | Lane B result |
| zValidA | output | 1 | Lane A output valid |
| zValidB | output | 1 | Lane B output valid |

## Verification
The hardest case to reach is saturation. Uniform random 16-bit operands overflow only about a quarter of the time, and they rarely land exactly on the boundary sums 32767 and -32768. The stimulus therefore biases part of the random draws toward operands of large magnitude and the same sign. Directed samples hit the exact edges (0x7FFF + 0x0000, 0x7FFF + 0x0001, 0x8000 + 0xFFFF, 0x8000 + 0x0000). Valid gaps are drawn independently per lane, so cycles where one lane holds its data while the other updates occur often. Together these exercise the clamp, the hold and the lane independence together.

// File: rtl/bias_pkg.sv
package bias_pkg;
  localparam int WORD_W = 16;
  localparam int FRAC_W = 8;

  typedef logic signed [WORD_W-1:0] word_t;

  typedef struct packed {
    logic load;
    logic addBias;
  } laneCtl_t;

  localparam word_t SAT_MAX = {1'b0, {(WORD_W-1){1'b1}}};
  localparam word_t SAT_MIN = {1'b1, {(WORD_W-1){1'b0}}};
endpackage

// File: rtl/biasLaneCtl.sv
module biasLaneCtl
  import bias_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     validIn,
  input  logic     routeEn,
  output laneCtl_t ctl,
  output logic     validOut
);
  always_comb begin
    ctl.load    = validIn;
    ctl.addBias = routeEn;
  end

  always_ff @(posedge clk) begin
    if (rst) validOut <= 1'b0;
    else     validOut <= validIn;
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    validIn |=> validOut); // R8
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (rst)
    !validIn |=> !validOut); // R5
endmodule

// File: rtl/biasLaneDp.sv
module biasLaneDp
  import bias_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  laneCtl_t ctl,
  input  word_t    dataIn,
  input  word_t    biasIn,
  output word_t    zOut
);
  localparam int SUM_W = WORD_W + 1;

  logic signed [SUM_W-1:0] wideSum;
  word_t                   satSum;
  word_t                   nextZ;

  always_comb begin
    wideSum = SUM_W'(dataIn) + SUM_W'(biasIn);
    if (wideSum[SUM_W-1] != wideSum[SUM_W-2])
      satSum = wideSum[SUM_W-1] ? SAT_MIN : SAT_MAX;
    else
      satSum = wideSum[WORD_W-1:0];
    nextZ = ctl.addBias ? satSum : dataIn;
  end

  always_ff @(posedge clk) begin
    if (rst)           zOut <= '0;
    else if (ctl.load) zOut <= nextZ;
  end

  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ctl.load |=> $stable(zOut)); // R5
  AST_PASS: assert property (@(posedge clk) disable iff (rst)
    (ctl.load && !ctl.addBias) |=> (zOut == $past(dataIn))); // R6
  AST_NO_POS_WRAP: assert property (@(posedge clk) disable iff (rst)
    (ctl.load && ctl.addBias && !dataIn[WORD_W-1] && !biasIn[WORD_W-1])
      |=> !zOut[WORD_W-1]); // R3
  AST_NO_NEG_WRAP: assert property (@(posedge clk) disable iff (rst)
    (ctl.load && ctl.addBias && dataIn[WORD_W-1] && biasIn[WORD_W-1])
      |=> zOut[WORD_W-1]); // R4
endmodule

// File: rtl/biasPairTop.sv
module biasPairTop
  import bias_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        routeEn,
  input  logic [15:0] biasA,
  input  logic [15:0] biasB,
  input  logic [15:0] dataA,
  input  logic [15:0] dataB,
  input  logic        validA,
  input  logic        validB,
  output logic [15:0] zA,
  output logic [15:0] zB,
  output logic        zValidA,
  output logic        zValidB
);
  localparam int LANES = 2;

  word_t dataV [LANES];
  word_t biasV [LANES];
  word_t zV    [LANES];
  logic  vIn   [LANES];
  logic  vOut  [LANES];

  always_comb begin
    dataV[0] = dataA;  dataV[1] = dataB;
    biasV[0] = biasA;  biasV[1] = biasB;
    vIn[0]   = validA; vIn[1]   = validB;
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    laneCtl_t laneCtl;
    biasLaneCtl i_ctl (
      .clk(clk), .rst(rst), .validIn(vIn[g]), .routeEn(routeEn),
      .ctl(laneCtl), .validOut(vOut[g])
    );
    biasLaneDp i_dp (
      .clk(clk), .rst(rst), .ctl(laneCtl),
      .dataIn(dataV[g]), .biasIn(biasV[g]), .zOut(zV[g])
    );
  end

  assign zA      = zV[0];
  assign zB      = zV[1];
  assign zValidA = vOut[0];
  assign zValidB = vOut[1];

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (zA == 16'h0 && zB == 16'h0 && !zValidA && !zValidB)); // R1
endmodule

// File: tb/test_biasPairTop.sv
module test_biasPairTop;
  logic clk = 1'b0;
  logic rst;
  logic routeEn;
  logic [15:0] biasA, biasB, dataA, dataB;
  logic validA, validB;
  logic [15:0] zA, zB;
  logic zValidA, zValidB;

  int total = 0;
  int bad = 0;
  logic [15:0] expA, expB;

  always #5 clk = ~clk;

  biasPairTop i_biasPairTop (
    .clk(clk), .rst(rst), .routeEn(routeEn),
    .biasA(biasA), .biasB(biasB), .dataA(dataA), .dataB(dataB),
    .validA(validA), .validB(validB),
    .zA(zA), .zB(zB), .zValidA(zValidA), .zValidB(zValidB)
  );

  function automatic logic [15:0] model(logic en, logic [15:0] d, logic [15:0] b);
    int s;
    if (!en) return d;
    s = $signed(d) + $signed(b);
    if (s > 32767)  return 16'h7FFF;
    if (s < -32768) return 16'h8000;
    return s[15:0];
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, step one edge, compare after the posedge
  task automatic step(logic en, logic va, logic [15:0] da, logic [15:0] ba,
                      logic vb, logic [15:0] db, logic [15:0] bb, string req);
    routeEn = en; validA = va; dataA = da; biasA = ba;
    validB = vb; dataB = db; biasB = bb;
    if (va) expA = model(en, da, ba);
    if (vb) expB = model(en, db, bb);
    @(posedge clk); #1;
    check(req, zA, expA);
    check(req, zB, expB);
    check(req, {15'd0, zValidA}, {15'd0, va});
    check(req, {15'd0, zValidB}, {15'd0, vb});
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1; routeEn = 1; validA = 0; validB = 0;
    dataA = 16'h1234; dataB = 16'h4321; biasA = 16'h0100; biasB = 16'h0100;
    repeat (3) @(posedge clk);
    #1;
    check("R1", zA, 16'h0); check("R1", zB, 16'h0);
    check("R1", {15'd0, zValidA}, 16'h0);
    @(negedge clk); rst = 0;
    @(posedge clk); #1;
    check("R1", {15'd0, zValidA}, 16'h0);
    check("R1", zB, 16'h0);
    @(negedge clk);
    expA = 16'h0; expB = 16'h0;

    // R2 basic adds (Q8.8: 1.5 + 0.25)
    step(1, 1, 16'h0180, 16'h0040, 1, 16'hFF00, 16'h0080, "R2");
    // R3 positive saturation edges
    step(1, 1, 16'h7FFF, 16'h0000, 1, 16'h7FFF, 16'h0001, "R3");
    step(1, 1, 16'h4000, 16'h4000, 1, 16'h7000, 16'h7000, "R3");
    // R4 negative saturation edges
    step(1, 1, 16'h8000, 16'h0000, 1, 16'h8000, 16'hFFFF, "R4");
    step(1, 1, 16'hC000, 16'hBFFF, 1, 16'h8001, 16'h8001, "R4");
    // R5 hold while invalid, R7 lanes independent
    step(1, 0, 16'h1111, 16'h1111, 1, 16'h0005, 16'h0001, "R5 R7");
    step(1, 1, 16'h0002, 16'h0003, 0, 16'h2222, 16'h2222, "R5 R7");
    step(1, 0, 16'h7777, 16'h0001, 0, 16'h7777, 16'h0001, "R5");
    // R6 bypass ignores bias
    step(0, 1, 16'h7FFF, 16'h7FFF, 1, 16'h8000, 16'hFFFF, "R6");
    step(0, 1, 16'h0123, 16'h5555, 0, 16'h0000, 16'h0000, "R6");
    // R8 back-to-back samples
    step(1, 1, 16'h0001, 16'h0001, 1, 16'h0010, 16'h0010, "R8");
    step(1, 1, 16'h0002, 16'h0002, 1, 16'h0020, 16'h0020, "R8");

    for (int i = 0; i < 400; i++) begin
      logic [15:0] da, ba, db, bb;
      da = $urandom; ba = $urandom; db = $urandom; bb = $urandom;
      if ($urandom_range(0, 3) == 0) begin
        da = {da[15], 2'b11 ^ {2{da[15]}}, da[12:0]};
        ba = {da[15], 2'b11 ^ {2{da[15]}}, ba[12:0]};
      end
      step($urandom_range(0, 4) != 0, $urandom_range(0, 3) != 0, da, ba,
           $urandom_range(0, 3) != 0, db, bb, "R2 R3 R4 R5 R6 R7");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule